// File: doc/BRIEF.md
# Line-Energy PHY Power-Down Controller

This controller lets an Ethernet PHY turn its own core off while the line is silent and bring it back when activity returns, with no host command needed. The host sets a mode bit to allow the behaviour. A raw energy-present indication comes from the always-on squelch and energy-detect path (set high by 100BASE-TX signalling, 10BASE-T signalling or auto-negotiation link pulses). It is brought into the PHY clock domain through two flops. It must then stay low for `QUIET_CYCLES` consecutive cycles before the core is shut down, so that the gaps between link pulses do not trip it.

The sequencer has four states. In POWERED the core runs normally. SAVING lasts one cycle: it pulses the save strobe so external storage captures the PHY state. In DOWN the core power domain is off and transmission is blocked. RESTORING lasts one cycle: power is back on and the restore strobe fires, but the core is still held out of operation. The sequencer then returns to POWERED. The transitions are:

- POWERED→SAVING: the mode bit is on and the silence timer has expired.
- SAVING→DOWN: always, after one cycle.
- DOWN→RESTORING: energy returns, or the mode bit is cleared.
- RESTORING→POWERED: always, after one cycle.

A wake-up caused by line energy sets a sticky flag. The host interrupt line follows that flag, gated by a mask bit. The first packet or two that cause a wake-up may be lost, and nothing here tries to keep them.

Top module: `line_energy_pd`

## Requirements
- R1: After reset the sequencer is in POWERED. `core_pwr_on`=1, `core_run`=1, `tx_inhibit`=0, both strobes are 0, `wake_flag`=0 and `host_irq`=0.
- R2: While `pd_mode_en` is 0, the sequencer never leaves POWERED, however long the line stays silent.
- R3: A silent run of fewer than `QUIET_CYCLES` synchronized cycles does not start a power-down.
- R4: With the mode on, `QUIET_CYCLES` consecutive silent synchronized cycles move POWERED to SAVING. In SAVING, `state_save` pulses for exactly one cycle and `core_run` is 0. The next state is DOWN, where `core_pwr_on` is 0.
- R5: `tx_inhibit` is 1 in every state except POWERED.
- R6: Energy returning in DOWN moves the sequencer to RESTORING for exactly one cycle. In RESTORING, `state_restore`=1, `core_pwr_on`=1 and `core_run`=0. POWERED follows, with `core_run`=1.
- R7: An energy-caused wake-up sets `wake_flag` in the same cycle the sequencer enters RESTORING. The flag then stays set until the host clears it.
- R8: `host_irq` equals `wake_flag` AND `wake_irq_en`, so a masked flag raises no interrupt.
- R9: A one-cycle `wake_flag_clr` pulse clears the flag on the next edge. If a new wake event arrives on the same edge, the set takes priority.
- R10: Clearing `pd_mode_en` while in DOWN moves the sequencer to RESTORING on the next edge, without setting `wake_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_mode_en | input | 1 | Mode control bit that allows energy-based power-down |
| line_energy_raw | input | 1 | Asynchronous energy-present indication from the squelch path |
| wake_irq_en | input | 1 | Interrupt mask bit for the wake event |
| wake_flag_clr | input | 1 | Host clear pulse for the wake flag (read or write-one-to-clear) |
| core_pwr_on | output | 1 | Power enable for the PHY core domain |
| core_run | output | 1 | Releases the PHY core into normal operation |
| tx_inhibit | output | 1 | Blocks all line transmission |
| state_save | output | 1 | One-cycle strobe to capture PHY state |
| state_restore | output | 1 | One-cycle strobe to reload PHY state |
| wake_flag | output | 1 | Sticky energy-on interrupt source flag |
| host_irq | output | 1 | Masked host interrupt |

## Verification
Input changes reach the sequencer only after the two synchronizer flops.

- **Power-down:** after the line falls silent, `state_save` is due QUIET_CYCLES+3 edges later and DOWN one edge after that. The bench first confirms that `core_run` is still high at edge QUIET_CYCLES+2.
- **Energy wake:** after energy returns, RESTORING and the set flag are due on the third edge and POWERED on the fourth.
- **Mode-bit wake:** clearing `pd_mode_en` in DOWN acts on the first edge, since that bit is not synchronized.
- **Flag and interrupt:** a clear pulse takes effect on the first edge. The mask gates the interrupt at once.

Every sample is taken 5 ns after the counted rising edge, and inputs change at the same point. Each check therefore reads a value that has settled.

// File: rtl/line_energy_pd_pkg.sv
package line_energy_pd_pkg;
    typedef enum logic [1:0] {
        ST_POWERED   = 2'd0,
        ST_SAVING    = 2'd1,
        ST_DOWN      = 2'd2,
        ST_RESTORING = 2'd3
    } pd_state_e;
endpackage

// File: rtl/lepd_sync.sv
module lepd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lepd_quiet_timer.sv
module lepd_quiet_timer #(
    parameter int QUIET_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic energy_s,
    output logic quiet
);
    localparam int CW = $clog2(QUIET_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUIET_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (energy_s || !mode_en) cnt <= '0;
        else if (cnt != LIMIT)     cnt <= cnt + 1'b1;
    end

    assign quiet = (cnt == LIMIT);

    // R3
    quiet_after_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> $past(!energy_s && mode_en));
endmodule

// File: rtl/lepd_fsm.sv
module lepd_fsm
    import line_energy_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic energy_s,
    input  logic quiet,
    output logic core_pwr_on,
    output logic core_run,
    output logic tx_inhibit,
    output logic state_save,
    output logic state_restore,
    output logic wake_evt
);
    pd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POWERED:   if (mode_en && quiet) state_nx = ST_SAVING;
            ST_SAVING:    state_nx = ST_DOWN;
            ST_DOWN:      if (!mode_en || energy_s) state_nx = ST_RESTORING;
            ST_RESTORING: state_nx = ST_POWERED;
            default:      state_nx = ST_POWERED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_POWERED;
        else        state <= state_nx;
    end

    always_comb begin
        core_pwr_on   = 1'b1;
        core_run      = 1'b0;
        tx_inhibit    = 1'b1;
        state_save    = 1'b0;
        state_restore = 1'b0;
        unique case (state)
            ST_POWERED: begin
                core_run   = 1'b1;
                tx_inhibit = 1'b0;
            end
            ST_SAVING:    state_save    = 1'b1;
            ST_DOWN:      core_pwr_on   = 1'b0;
            ST_RESTORING: state_restore = 1'b1;
            default: ;
        endcase
    end

    assign wake_evt = (state == ST_DOWN) && mode_en && energy_s;

    // R2
    stay_powered_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_en && state == ST_POWERED) |=> (state == ST_POWERED));
    // R4
    save_then_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_save |=> (!state_save && !core_pwr_on));
    // R6
    run_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> $past(state_restore));
    // R10
    off_forces_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN && !mode_en) |=> state_restore);
endmodule

// File: rtl/lepd_wake_flag.sv
module lepd_wake_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    // R7
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R9
    flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/line_energy_pd.sv
module line_energy_pd #(
    parameter int QUIET_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_mode_en,
    input  logic line_energy_raw,
    input  logic wake_irq_en,
    input  logic wake_flag_clr,
    output logic core_pwr_on,
    output logic core_run,
    output logic tx_inhibit,
    output logic state_save,
    output logic state_restore,
    output logic wake_flag,
    output logic host_irq
);
    logic energy_s, quiet, wake_evt;

    lepd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(line_energy_raw), .sync_out(energy_s)
    );

    lepd_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .mode_en(pd_mode_en), .energy_s(energy_s), .quiet(quiet)
    );

    lepd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_en(pd_mode_en), .energy_s(energy_s), .quiet(quiet),
        .core_pwr_on(core_pwr_on), .core_run(core_run), .tx_inhibit(tx_inhibit),
        .state_save(state_save), .state_restore(state_restore), .wake_evt(wake_evt)
    );

    lepd_wake_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(wake_evt), .clr(wake_flag_clr),
        .irq_en(wake_irq_en), .flag(wake_flag), .irq(host_irq)
    );

    // R5
    tx_blocked_when_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_pwr_on |-> tx_inhibit);
    // R8
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (wake_flag && wake_irq_en));
endmodule

// File: tb/tb_line_energy_pd.sv
`timescale 1ns/1ps
module tb_line_energy_pd;
    localparam int QC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_mode_en = 1'b0, line_energy_raw = 1'b1, wake_irq_en = 1'b0, wake_flag_clr = 1'b0;
    logic core_pwr_on, core_run, tx_inhibit, state_save, state_restore, wake_flag, host_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    line_energy_pd #(.QUIET_CYCLES(QC)) dut (
        .clk(clk), .rst_n(rst_n), .pd_mode_en(pd_mode_en), .line_energy_raw(line_energy_raw),
        .wake_irq_en(wake_irq_en), .wake_flag_clr(wake_flag_clr),
        .core_pwr_on(core_pwr_on), .core_run(core_run), .tx_inhibit(tx_inhibit),
        .state_save(state_save), .state_restore(state_restore),
        .wake_flag(wake_flag), .host_irq(host_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic t_reset;
        chk("R1 core_pwr_on", core_pwr_on, 1'b1);
        chk("R1 core_run", core_run, 1'b1);
        chk("R1 tx_inhibit", tx_inhibit, 1'b0);
        chk("R1 state_save", state_save, 1'b0);
        chk("R1 state_restore", state_restore, 1'b0);
        chk("R1 wake_flag", wake_flag, 1'b0);
        chk("R1 host_irq", host_irq, 1'b0);
    endtask

    task automatic t_disabled;
        pd_mode_en = 1'b0;
        line_energy_raw = 1'b0;
        for (int i = 0; i < 3 * QC; i++) begin
            edges(1);
            if (!core_run || tx_inhibit || state_save) begin
                chk("R2 stays powered", 1'b0, 1'b1);
                break;
            end
        end
        chk("R2 core_run", core_run, 1'b1);
        line_energy_raw = 1'b1;
        edges(3);
    endtask

    task automatic t_gap_filter;
        pd_mode_en = 1'b1;
        line_energy_raw = 1'b0;
        edges(QC - 1);
        line_energy_raw = 1'b1;
        for (int i = 0; i < QC + 4; i++) begin
            edges(1);
            if (state_save || !core_run) begin
                chk("R3 short gap no save", 1'b0, 1'b1);
                break;
            end
        end
        chk("R3 core_run", core_run, 1'b1);
    endtask

    task automatic go_down;
        line_energy_raw = 1'b0;
        edges(QC + 2);
        chk("R4 still run before limit", core_run, 1'b1);
        chk("R4 no save yet", state_save, 1'b0);
        edges(1);
        chk("R4 save strobe", state_save, 1'b1);
        chk("R4 core_run off in SAVING", core_run, 1'b0);
        chk("R5 tx_inhibit in SAVING", tx_inhibit, 1'b1);
        edges(1);
        chk("R4 save one cycle", state_save, 1'b0);
        chk("R4 core power off in DOWN", core_pwr_on, 1'b0);
        chk("R5 tx_inhibit in DOWN", tx_inhibit, 1'b1);
    endtask

    task automatic t_energy_wake_masked;
        wake_irq_en = 1'b0;
        go_down();
        edges(5);
        chk("R4 stays DOWN while silent", core_pwr_on, 1'b0);
        line_energy_raw = 1'b1;
        edges(2);
        chk("R6 not yet restoring", state_restore, 1'b0);
        edges(1);
        chk("R6 restore strobe", state_restore, 1'b1);
        chk("R6 power on in RESTORING", core_pwr_on, 1'b1);
        chk("R6 core held in RESTORING", core_run, 1'b0);
        chk("R5 tx_inhibit in RESTORING", tx_inhibit, 1'b1);
        chk("R7 flag set", wake_flag, 1'b1);
        chk("R8 masked irq", host_irq, 1'b0);
        edges(1);
        chk("R6 back to run", core_run, 1'b1);
        chk("R6 restore one cycle", state_restore, 1'b0);
        chk("R5 tx released", tx_inhibit, 1'b0);
        edges(6);
        chk("R7 flag sticky", wake_flag, 1'b1);
        wake_irq_en = 1'b1;
        #1;
        chk("R8 irq on unmask", host_irq, 1'b1);
        wake_flag_clr = 1'b1;
        edges(1);
        wake_flag_clr = 1'b0;
        chk("R9 flag cleared", wake_flag, 1'b0);
        chk("R9 irq cleared", host_irq, 1'b0);
    endtask

    task automatic t_set_beats_clear;
        wake_irq_en = 1'b1;
        go_down();
        line_energy_raw = 1'b1;
        edges(2);
        wake_flag_clr = 1'b1;
        edges(1);
        wake_flag_clr = 1'b0;
        chk("R9 set wins over clear", wake_flag, 1'b1);
        chk("R8 irq with mask on", host_irq, 1'b1);
        wake_flag_clr = 1'b1;
        edges(1);
        wake_flag_clr = 1'b0;
        chk("R9 cleared afterwards", wake_flag, 1'b0);
        edges(2);
    endtask

    task automatic t_disable_in_down;
        go_down();
        pd_mode_en = 1'b0;
        edges(1);
        chk("R10 restore on disable", state_restore, 1'b1);
        chk("R10 no flag", wake_flag, 1'b0);
        edges(1);
        chk("R10 back to run", core_run, 1'b1);
        edges(2 * QC);
        chk("R10 stays powered while off", core_run, 1'b1);
        chk("R10 flag still clear", wake_flag, 1'b0);
        line_energy_raw = 1'b1;
        edges(3);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_disabled();
        t_gap_filter();
        t_energy_wake_masked();
        t_set_beats_clear();
        t_disable_in_down();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule